// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory Bank

This block is a bank of 64-bit words. Each word carries a four-bit access state: a full/empty flag, an indirect-forwarding flag, a load trap and a store trap. Loads and stores arrive with a byte address, a synchronization mode, the requester's protection domain and the number of times the requester has already retried the access. The bank answers each request one cycle later with a response code, any read data, and the word's access state after the access.

A synchronizing access that finds the full/empty flag in the wrong state changes nothing and asks the requester to try again. Once the requester's retry count reaches the limit set for its domain, the bank reports a limit trap instead. The data field and the access-state field each have their own single-error-correcting, double-error-detecting check code. A single flipped bit is corrected and scrubbed when the word is accessed. A double error in either field makes the word answer with an error.

Tag layout: bit 0 full, bit 1 indirect, bit 2 load trap, bit 3 store trap. Response codes: 0 OK, 1 RETRY, 2 LIMIT, 3 TRAP, 4 FWD, 5 ERR. Modes: 0 plain, 1 wait-full and stay full, 2 consume/produce, 3 store and set full.

Top module: `tagged_sync_mem`

## Requirements
- R1: After reset every word holds data 0 with access state 0 (empty, no traps, not indirect). Every domain limit equals RESET_LIMIT (default 3). rsp_valid is low.
- R2: A request accepted at a clock edge is answered with rsp_valid high at the next edge, and only then. The word index is req_addr[BYTE_AW-1:3], and the three low address bits do not select anything. rsp_code is always one of 0 to 5.
- R3: In mode 0 a load returns the stored data and a store writes req_wdata, without testing or changing the full flag. A store response carries rdata 0.
- R4: In mode 1 a load or store succeeds only when the word is full, and it leaves the word full.
- R5: In mode 2 a load needs a full word and leaves it empty; a store needs an empty word and leaves it full.
- R6: In mode 3 a store always succeeds and sets the word full, whatever its previous state.
- R7: A synchronizing access whose full/empty test fails, with req_retry below its domain's limit, returns code 1 and leaves the word unchanged.
- R8: When the test fails and req_retry is at or above the limit of req_domain, the code is 2. Limits are per domain and are written through lim_we/lim_domain/lim_value.
- R9: A load to a word with tag bit 2 set, or a store to a word with tag bit 3 set, returns code 3 and leaves the word unchanged.
- R10: A word with tag bit 1 set answers any access with code 4, the stored data and no change. A store with req_tag_we writes req_wdata and all four tag bits, bypassing the trap, indirect and full/empty checks.
- R11: A single flipped bit in a stored data codeword is corrected: the access returns the original value with code 0, and the word is rewritten in correct form.
- R12: A double error in the data field or the tag field makes any access return code 5 with rdata 0 and rsp_tag 0, and the word is not modified. req_inject applies to a store's write: 1 flips one data bit, 2 flips two data bits, 3 flips two tag bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 store, 0 load |
| req_mode | input | 2 | Synchronization mode |
| req_domain | input | DOM_W | Requester protection domain |
| req_retry | input | RETRY_W | Retries already made by this request |
| req_addr | input | BYTE_AW | Byte address |
| req_wdata | input | 64 | Store data |
| req_tag_we | input | 1 | Store also writes the access-state bits |
| req_tag | input | 4 | Access state written when req_tag_we |
| req_inject | input | 2 | Check-bit corruption applied to a store |
| lim_we | input | 1 | Write a domain retry limit |
| lim_domain | input | DOM_W | Domain whose limit is written |
| lim_value | input | RETRY_W | New retry limit |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 3 | Response code |
| rsp_rdata | output | 64 | Load or forwarding data |
| rsp_tag | output | 4 | Access state after the access |

## Verification
The hardest condition to reach is the retry limit in a domain other than the default. It needs a word left empty by a consuming load, a limit rewritten for one domain, and then failing loads from two domains with retry counts on either side of their limits. The stimulus first drains a word with a mode 2 load. It then lowers one domain's limit to zero and shows that the same failing load gives a retry in one domain and a limit trap in the other. Check-code faults cannot occur on their own, so stores with corruption injected set up single and double errors in separate words, and later loads observe them.

// File: rtl/tagged_sync_mem.sv
module tagged_sync_mem #(
  parameter int BYTE_AW     = 7,
  parameter int DOMAINS     = 16,
  parameter int RETRY_W     = 4,
  parameter int RESET_LIMIT = 3,
  localparam int WORDS = 1 << (BYTE_AW - 3),
  localparam int DOM_W = $clog2(DOMAINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_store,
  input  logic [1:0]         req_mode,
  input  logic [DOM_W-1:0]   req_domain,
  input  logic [RETRY_W-1:0] req_retry,
  input  logic [BYTE_AW-1:0] req_addr,
  input  logic [63:0]        req_wdata,
  input  logic               req_tag_we,
  input  logic [3:0]         req_tag,
  input  logic [1:0]         req_inject,
  input  logic               lim_we,
  input  logic [DOM_W-1:0]   lim_domain,
  input  logic [RETRY_W-1:0] lim_value,
  output logic               rsp_valid,
  output logic [2:0]         rsp_code,
  output logic [63:0]        rsp_rdata,
  output logic [3:0]         rsp_tag
);
  localparam logic [2:0] C_OK = 3'd0, C_RETRY = 3'd1, C_LIMIT = 3'd2,
                         C_TRAP = 3'd3, C_FWD = 3'd4, C_ERR = 3'd5;

  function automatic logic [71:0] enc(input logic [63:0] d, input int k, input int n);
    logic [71:0] c;
    int di;
    c = '0;
    di = 0;
    for (int p = 1; p < 72; p++)
      if (p <= n && (p & (p - 1)) != 0 && di < k) begin
        c[p] = d[di];
        di++;
      end
    for (int j = 0; j < 7; j++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p < 72; p++)
        if (p <= n && ((p >> j) & 1) == 1) x ^= c[p];
      if ((1 << j) <= n) c[1 << j] = x;
    end
    c[0] = ^c;
    return c;
  endfunction

  function automatic logic [6:0] syn(input logic [71:0] c, input int n);
    logic [6:0] s;
    s = '0;
    for (int p = 1; p < 72; p++)
      if (p <= n && c[p]) s ^= 7'(p);
    return s;
  endfunction

  function automatic logic [71:0] fix(input logic [71:0] c, input int n);
    logic [71:0] r;
    logic [6:0] s;
    r = c;
    s = syn(c, n);
    if (^c && int'(s) <= n) r[s] = ~r[s];
    return r;
  endfunction

  function automatic logic unc(input logic [71:0] c, input int n);
    logic [6:0] s;
    s = syn(c, n);
    return (s != 0 && !(^c)) || (^c && int'(s) > n);
  endfunction

  function automatic logic [63:0] ext(input logic [71:0] c, input int k, input int n);
    logic [63:0] r;
    int di;
    r = '0;
    di = 0;
    for (int p = 1; p < 72; p++)
      if (p <= n && (p & (p - 1)) != 0 && di < k) begin
        r[di] = c[p];
        di++;
      end
    return r;
  endfunction

  logic [71:0]        mem_d [WORDS];
  logic [7:0]         mem_t [WORDS];
  logic [RETRY_W-1:0] lim   [DOMAINS];

  logic [BYTE_AW-4:0] widx;
  logic [71:0] dcw, tcw;
  logic [63:0] dval, nd;
  logic [3:0]  tval, nt;
  logic        bad, pass, wr;
  logic [2:0]  code;
  logic [71:0] dflip;
  logic [7:0]  tflip;

  assign widx = req_addr[BYTE_AW-1:3];
  assign dcw  = mem_d[widx];
  assign tcw  = {64'b0, mem_t[widx]};
  assign bad  = unc(dcw, 71) | unc(tcw, 7);
  assign dval = ext(fix(dcw, 71), 64, 71);
  assign tval = 4'(ext(fix(tcw, 7), 4, 7));
  assign pass = (req_mode == 2'd1) ? tval[0] :
                (req_mode == 2'd2) ? (req_store ? !tval[0] : tval[0]) : 1'b1;
  assign dflip = !req_store ? 72'h0 : (req_inject == 2'd1) ? 72'h2 :
                 (req_inject == 2'd2) ? 72'h6 : 72'h0;
  assign tflip = (req_store && req_inject == 2'd3) ? 8'h6 : 8'h0;

  always_comb begin
    code = C_OK;
    wr   = 1'b0;
    nd   = dval;
    nt   = tval;
    if (bad) code = C_ERR;
    else if (req_store && req_tag_we) begin
      wr = 1'b1;
      nd = req_wdata;
      nt = req_tag;
    end
    else if (tval[1]) code = C_FWD;
    else if (req_store ? tval[3] : tval[2]) code = C_TRAP;
    else if (!pass) code = (req_retry >= lim[req_domain]) ? C_LIMIT : C_RETRY;
    else begin
      wr = 1'b1;
      if (req_store) nd = req_wdata;
      if (req_mode == 2'd2) nt[0] = req_store;
      else if (req_mode == 2'd3 && req_store) nt[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        mem_d[i] <= '0;
        mem_t[i] <= '0;
      end
      for (int i = 0; i < DOMAINS; i++) lim[i] <= RETRY_W'(RESET_LIMIT);
      rsp_valid <= 1'b0;
      rsp_code  <= C_OK;
      rsp_rdata <= '0;
      rsp_tag   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (lim_we) lim[lim_domain] <= lim_value;
      if (req_valid) begin
        rsp_code  <= code;
        rsp_rdata <= (code == C_FWD || (code == C_OK && !req_store)) ? dval : 64'h0;
        rsp_tag   <= bad ? 4'h0 : nt;
        if (wr) begin
          mem_d[widx] <= enc(nd, 64, 71) ^ dflip;
          mem_t[widx] <= 8'(enc({60'b0, nt}, 4, 7)) ^ tflip;
        end
      end
    end
  end
endmodule

// File: rtl/tagged_sync_mem_checker.sv
module tagged_sync_mem_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_store,
  input logic [1:0]  req_mode,
  input logic        req_tag_we,
  input logic        rsp_valid,
  input logic [2:0]  rsp_code,
  input logic [63:0] rsp_rdata,
  input logic [3:0]  rsp_tag
);
  assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (rsp_valid == $past(req_valid)));

  assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code <= 3'd5));

  assert_retry_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd1) |-> ($past(req_mode) == 2'd1 || $past(req_mode) == 2'd2));

  assert_limit_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd2) |-> ($past(req_mode) == 2'd1 || $past(req_mode) == 2'd2));

  assert_consume_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd0 && $past(req_mode) == 2'd2 && !$past(req_store)) |-> !rsp_tag[0]);

  assert_fill_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd0 && $past(req_store) && !$past(req_tag_we) && $past(req_mode[1]))
      |-> rsp_tag[0]);

  assert_err_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd5) |-> (rsp_rdata == 64'h0 && rsp_tag == 4'h0));
endmodule

bind tagged_sync_mem tagged_sync_mem_checker u_chk (.*);

// File: tb/sim_tagged_sync_mem.sv
`timescale 1ns/1ps
module sim_tagged_sync_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_tag_we = 1'b0, lim_we = 1'b0;
  logic [1:0]  req_mode = '0, req_inject = '0;
  logic [3:0]  req_domain = '0, lim_domain = '0, req_retry = '0, lim_value = '0, req_tag = '0;
  logic [6:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_code;
  logic [63:0] rsp_rdata;
  logic [3:0]  rsp_tag;

  tagged_sync_mem u0 (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic [2:0]  code;
    logic [63:0] data;
    logic [3:0]  tag;
    string       rq;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] mdata [16];
  logic [3:0]  mtag  [16];
  bit          mbad  [16];
  int          mlim  [16];

  task automatic issue(input bit st, input logic [1:0] md, input int dom, input int rt,
                       input int addr, input logic [63:0] wd, input bit twe,
                       input logic [3:0] tg, input logic [1:0] inj, input string rq);
    exp_t e;
    int w;
    bit pass, wr;
    w = (addr >> 3) & 15;
    e.rq = rq; e.data = 0; e.tag = mtag[w]; e.code = 0; wr = 0;
    pass = (md == 1) ? mtag[w][0] : (md == 2) ? (st ? !mtag[w][0] : mtag[w][0]) : 1;
    if (mbad[w]) begin e.code = 5; e.tag = 0; end
    else if (st && twe) begin wr = 1; mdata[w] = wd; mtag[w] = tg; e.tag = tg; end
    else if (mtag[w][1]) begin e.code = 4; e.data = mdata[w]; end
    else if (st ? mtag[w][3] : mtag[w][2]) e.code = 3;
    else if (!pass) e.code = (rt >= mlim[dom]) ? 2 : 1;
    else begin
      wr = 1;
      if (st) mdata[w] = wd; else e.data = mdata[w];
      if (md == 2) mtag[w][0] = st;
      else if (md == 3 && st) mtag[w][0] = 1;
      e.tag = mtag[w];
    end
    if (wr && st && (inj == 2 || inj == 3)) mbad[w] = 1;
    q.push_back(e);
    req_valid = 1; req_store = st; req_mode = md; req_domain = 4'(dom); req_retry = 4'(rt);
    req_addr = 7'(addr); req_wdata = wd; req_tag_we = twe; req_tag = tg; req_inject = inj;
    @(negedge clk);
    req_valid = 0; req_tag_we = 0; req_inject = 0;
  endtask

  task automatic set_lim(input int dom, input int v);
    lim_we = 1; lim_domain = 4'(dom); lim_value = 4'(v);
    @(negedge clk);
    lim_we = 0;
    mlim[dom] = v;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected response code=%0d expected none", rsp_code);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_code !== e.code || rsp_rdata !== e.data || rsp_tag !== e.tag) begin
          fails++;
          $display("FAIL %s: code=%0d data=%h tag=%h expected code=%0d data=%h tag=%h",
                   e.rq, rsp_code, rsp_rdata, rsp_tag, e.code, e.data, e.tag);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mdata[i] = 0; mtag[i] = 0; mbad[i] = 0; mlim[i] = 3; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin fails++; $display("FAIL R1: rsp_valid=%b expected 0", rsp_valid); end
    // R1 reset contents
    issue(0, 0, 1, 0, 0,  0, 0, 0, 0, "R1");
    issue(0, 0, 1, 0, 40, 0, 0, 0, 0, "R1");
    // R2 low address bits ignored, R3 plain access
    issue(1, 0, 1, 0, 8+5, 64'hA5A5_0000_1234_5678, 0, 0, 0, "R2");
    issue(0, 0, 1, 0, 8,   0, 0, 0, 0, "R3");
    issue(0, 0, 1, 0, 8+7, 0, 0, 0, 0, "R2");
    // R4/R5 sync modes on word 1
    issue(0, 1, 1, 0, 8, 0, 0, 0, 0, "R4");
    issue(1, 2, 1, 0, 8, 64'hBBBB_CCCC_DDDD_0001, 0, 0, 0, "R5");
    issue(0, 1, 1, 0, 8, 0, 0, 0, 0, "R4");
    issue(1, 1, 1, 0, 8, 64'h0123_4567_89AB_CDEF, 0, 0, 0, "R4");
    issue(0, 2, 1, 0, 8, 0, 0, 0, 0, "R5");
    // R7 retry and R8 limit with default limit
    issue(0, 2, 1, 0, 8, 0, 0, 0, 0, "R7");
    issue(0, 2, 1, 2, 8, 0, 0, 0, 0, "R7");
    issue(0, 2, 1, 3, 8, 0, 0, 0, 0, "R8");
    // R8 per-domain limit
    set_lim(2, 0);
    issue(0, 2, 2, 0, 8, 0, 0, 0, 0, "R8");
    issue(0, 2, 1, 1, 8, 0, 0, 0, 0, "R8");
    set_lim(1, 9);
    issue(0, 2, 1, 8, 8, 0, 0, 0, 0, "R8");
    issue(0, 2, 1, 9, 8, 0, 0, 0, 0, "R8");
    // R6 unconditional set-full store
    issue(1, 3, 1, 0, 16, 64'h1111, 0, 0, 0, "R6");
    issue(1, 3, 1, 0, 16, 64'h2222, 0, 0, 0, "R6");
    issue(1, 2, 1, 0, 16, 64'h3333, 0, 0, 0, "R7");
    issue(0, 0, 1, 0, 16, 0, 0, 0, 0, "R6");
    // R9 trap bits
    issue(1, 0, 1, 0, 24, 64'hD00D, 1, 4'b0100, 0, "R10");
    issue(0, 0, 1, 0, 24, 0, 0, 0, 0, "R9");
    issue(1, 0, 1, 0, 24, 64'hE00E, 0, 0, 0, "R9");
    issue(1, 0, 1, 0, 24, 64'hE00E, 1, 4'b1000, 0, "R10");
    issue(1, 3, 1, 0, 24, 64'hF00F, 0, 0, 0, "R9");
    issue(0, 0, 1, 0, 24, 0, 0, 0, 0, "R9");
    // R10 indirect forwarding and tag write
    issue(1, 0, 1, 0, 32, 64'h0000_0000_0000_0040, 1, 4'b0011, 0, "R10");
    issue(0, 2, 1, 0, 32, 0, 0, 0, 0, "R10");
    issue(1, 3, 1, 0, 32, 64'h9999, 0, 0, 0, "R10");
    issue(1, 0, 1, 0, 32, 64'h7777, 1, 4'b0000, 0, "R10");
    issue(0, 0, 1, 0, 32, 0, 0, 0, 0, "R10");
    // R11 single error corrected and scrubbed
    issue(1, 0, 1, 0, 48, 64'hCAFE_F00D_1357_2468, 0, 0, 2'd1, "R11");
    issue(0, 0, 1, 0, 48, 0, 0, 0, 0, "R11");
    issue(0, 0, 1, 0, 48, 0, 0, 0, 0, "R11");
    // R12 double errors in data and in tag
    issue(1, 0, 1, 0, 56, 64'h5555, 0, 0, 2'd2, "R12");
    issue(0, 0, 1, 0, 56, 0, 0, 0, 0, "R12");
    issue(1, 0, 1, 0, 56, 64'h6666, 1, 4'b0001, 0, "R12");
    issue(1, 3, 1, 0, 64, 64'h8888, 0, 0, 2'd3, "R12");
    issue(0, 0, 1, 0, 64, 0, 0, 0, 0, "R12");
    issue(0, 0, 1, 0, 56, 0, 0, 0, 0, "R12");
    repeat (2) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d responses missing expected 0", q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule